// File: doc/BRIEF.md
# Packed Configuration Stream Interpreter

The block walks a stream of configuration records held in memory and turns each record into 16-bit register writes on two PHY register ports. A pulse on `start_i` latches the stream's base byte address. The block then reads the stream one byte at a time through a simple request/valid read port. The stream opens with a header that carries a fixed 64-bit signature, four one-byte descriptors, eight spare bytes and a 32-bit record count. The records that follow have different lengths, and the block decodes them in order.

The opcode in a record selects one of four actions: a write to one port, a write broadcast to both ports, a burst of consecutive halfwords written to both ports, or a wait for one PHY's training result. The training result arrives through an external request / ok / fail handshake that stands in for the message channel. The block ends in one of two ways. On success it pulses `done_o` for one cycle. On failure it pulses `err_o` and holds a reason in `err_code_o` until the next start.

Top module: `cfgs_stream_exec`

## Requirements
- R1: If the first eight stream bytes, read little-endian, do not equal 0x4452444445415448, the block pulses `err_o` with `err_code_o` = 1, issues no PHY write and does not pulse `done_o`.
- R2: The record count is the little-endian 32-bit value at byte offset 20 of the header. A count of zero ends the run with a `done_o` pulse and no PHY write.
- R3: Each record starts with a little-endian 32-bit word. Bits 31:24 are the opcode and bits 23:0 are a halfword index. The write byte address on `wr_addr_o` is the index times 2.
- R4: Opcode 0 writes the next little-endian 16-bit word to port 0 only (bit 0 of `wr_valid_o`). Opcode 1 writes it to port 1 only (bit 1). Each such record is 6 bytes long.
- R5: Opcode 2 writes the same word to both ports. No later byte is fetched until both ports have accepted the write.
- R6: Opcode 3 is followed by a 32-bit count N and then N halfwords. Halfword j is written to both ports at byte address 2*index + 2*j. The record is 8+2N bytes long, and N = 0 writes nothing.
- R7: Opcode 4 raises `train_req_o` bit 0 and opcode 5 raises bit 1, one at a time. `train_ok_i` moves the block on to the next record. `train_fail_i` ends the run with `err_code_o` = 3 and no further writes.
- R8: Any opcode above 5 ends the run with `err_o` and `err_code_o` = 2, with no further writes.
- R9: Records are packed back to back with no padding, at any base byte alignment.
- R10: `done_o` is a single-cycle pulse and never coincides with `err_o`. A new start is then accepted, and it clears `err_code_o` to 0.
- R11: While `mem_rd_o` is high, `mem_addr_o` stays stable until `mem_rvalid_i` returns the byte.
- R12: A port whose valid bit is high and whose ready is low keeps its valid bit, `wr_addr_o` and `wr_data_o` unchanged in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin a run (accepted when idle) |
| base_i | input | MEM_AW | Byte address of the stream header |
| mem_rd_o | output | 1 | Byte read request |
| mem_addr_o | output | MEM_AW | Byte read address |
| mem_rvalid_i | input | 1 | Read byte valid (one cycle) |
| mem_rdata_i | input | 8 | Read byte |
| wr_valid_o | output | NPHY | Per-port write valid |
| wr_ready_i | input | NPHY | Per-port write accept |
| wr_addr_o | output | PA_W | Write byte address, shared by the ports |
| wr_data_o | output | DW | Write data, shared by the ports |
| train_req_o | output | NPHY | Training-result wait, one bit per PHY |
| train_ok_i | input | 1 | Training succeeded (pulse) |
| train_fail_i | input | 1 | Training failed (pulse) |
| done_o | output | 1 | Run finished cleanly (pulse) |
| err_o | output | 1 | Run aborted (pulse) |
| err_code_o | output | 2 | 0 none, 1 bad signature, 2 bad opcode, 3 training failure |

## Verification
The bench targets the corner cases that a wrong design gets wrong in visible ways:
- A signature check off by one byte would let writes leak out before the signature error.
- A design that miscounts the length of a range record would decode burst data as opcodes, so the next record would land at the wrong address or raise a false opcode error. Zero-length bursts and unaligned stream bases expose this.
- A broadcast that moved on after only one port accepted would start fetching while port 1 is still stalled.
- A training failure or bad opcode that did not stop the walk would produce extra writes after the failing record.

// File: rtl/cfgs_pkg.sv
package cfgs_pkg;
    localparam logic [63:0] HDR_SIGNATURE = 64'h4452444445415448;

    localparam logic [7:0] OPC_WR0   = 8'd0;
    localparam logic [7:0] OPC_WR1   = 8'd1;
    localparam logic [7:0] OPC_WRB   = 8'd2;
    localparam logic [7:0] OPC_BURST = 8'd3;
    localparam logic [7:0] OPC_TRN0  = 8'd4;
    localparam logic [7:0] OPC_TRN1  = 8'd5;

    typedef enum logic [1:0] {
        FAULT_NONE   = 2'd0,
        FAULT_SIG    = 2'd1,
        FAULT_OPCODE = 2'd2,
        FAULT_TRAIN  = 2'd3
    } fault_e;

    typedef enum logic [3:0] {
        ST_IDLE, ST_SIG, ST_INFO, ST_SPARE, ST_COUNT,
        ST_RECHDR, ST_WDATA, ST_WRITE, ST_BLEN, ST_BDATA,
        ST_BWRITE, ST_TRAIN
    } walk_e;

    typedef struct packed {
        logic [7:0]  opc;
        logic [23:0] idx;
    } rec_word_t;

    function automatic logic [1:0] port_mask(input logic [7:0] opc);
        case (opc)
            OPC_WR0: port_mask = 2'b01;
            OPC_WR1: port_mask = 2'b10;
            default: port_mask = 2'b11;
        endcase
    endfunction
endpackage

// File: rtl/cfgs_byte_fetch.sv
module cfgs_byte_fetch #(
    parameter int MEM_AW = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ptr_load,
    input  logic [MEM_AW-1:0] ptr_base,
    input  logic              go,
    input  logic [3:0]        nbytes,
    input  logic              rvalid,
    input  logic [7:0]        rdata,
    output logic              rd,
    output logic [MEM_AW-1:0] addr,
    output logic              done,
    output logic [63:0]       value
);
    logic              active;
    logic [3:0]        cnt;
    logic [3:0]        want;
    logic [MEM_AW-1:0] ptr;
    logic [63:0]       acc;

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b0;
            cnt    <= '0;
            want   <= '0;
            ptr    <= '0;
            acc    <= '0;
            done   <= 1'b0;
        end else begin
            done <= 1'b0;
            if (ptr_load) ptr <= ptr_base;
            if (go) begin
                active <= 1'b1;
                cnt    <= '0;
                want   <= nbytes;
                acc    <= '0;
            end else if (active && rvalid) begin
                acc[cnt[2:0]*8 +: 8] <= rdata;
                ptr <= ptr + 1'b1;
                cnt <= cnt + 4'd1;
                if (cnt == want - 4'd1) begin
                    active <= 1'b0;
                    done   <= 1'b1;
                end
            end
        end
    end

    assign rd    = active;
    assign addr  = ptr;
    assign value = acc;
endmodule

// File: rtl/cfgs_phy_issue.sv
module cfgs_phy_issue #(
    parameter int NPHY = 2,
    parameter int PA_W = 25,
    parameter int DW   = 16
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            go,
    input  logic [NPHY-1:0] mask,
    input  logic [PA_W-1:0] addr_in,
    input  logic [DW-1:0]   data_in,
    input  logic [NPHY-1:0] ready,
    output logic [NPHY-1:0] valid,
    output logic [PA_W-1:0] addr,
    output logic [DW-1:0]   data,
    output logic            idle
);
    logic [NPHY-1:0] pend;

    for (genvar p = 0; p < NPHY; p++) begin : g_port
        always_ff @(posedge clk) begin
            if (rst)                     pend[p] <= 1'b0;
            else if (go)                 pend[p] <= mask[p];
            else if (pend[p] && ready[p]) pend[p] <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            addr <= '0;
            data <= '0;
        end else if (go) begin
            addr <= addr_in;
            data <= data_in;
        end
    end

    assign valid = pend;
    assign idle  = (pend == '0);
endmodule

// File: rtl/cfgs_stream_exec.sv
module cfgs_stream_exec
    import cfgs_pkg::*;
#(
    parameter int MEM_AW = 16,
    parameter int NPHY   = 2,
    parameter int IDX_W  = 24,
    parameter int DW     = 16,
    localparam int PA_W  = IDX_W + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic [MEM_AW-1:0] base_i,
    output logic              mem_rd_o,
    output logic [MEM_AW-1:0] mem_addr_o,
    input  logic              mem_rvalid_i,
    input  logic [7:0]        mem_rdata_i,
    output logic [NPHY-1:0]   wr_valid_o,
    input  logic [NPHY-1:0]   wr_ready_i,
    output logic [PA_W-1:0]   wr_addr_o,
    output logic [DW-1:0]     wr_data_o,
    output logic [NPHY-1:0]   train_req_o,
    input  logic              train_ok_i,
    input  logic              train_fail_i,
    output logic              done_o,
    output logic              err_o,
    output logic [1:0]        err_code_o
);
    walk_e       st, nxt;
    logic [31:0] recs_left, burst_left;
    logic [7:0]  cur_opc;
    logic [PA_W-1:0] cur_addr;
    logic        done_q, err_q;
    fault_e      code_q, fault_c;

    logic        f_go, f_ld, f_done;
    logic [3:0]  f_n;
    logic [63:0] f_val;
    logic        w_go, w_idle;
    logic [NPHY-1:0] w_mask;
    logic        rec_end, fin_ok, fin_err;
    rec_word_t   rw;

    assign rw = rec_word_t'(f_val[31:0]);

    cfgs_byte_fetch #(.MEM_AW(MEM_AW)) u_fetch (
        .clk(clk), .rst(rst), .ptr_load(f_ld), .ptr_base(base_i),
        .go(f_go), .nbytes(f_n), .rvalid(mem_rvalid_i), .rdata(mem_rdata_i),
        .rd(mem_rd_o), .addr(mem_addr_o), .done(f_done), .value(f_val)
    );

    cfgs_phy_issue #(.NPHY(NPHY), .PA_W(PA_W), .DW(DW)) u_issue (
        .clk(clk), .rst(rst), .go(w_go), .mask(w_mask),
        .addr_in(cur_addr), .data_in(f_val[DW-1:0]), .ready(wr_ready_i),
        .valid(wr_valid_o), .addr(wr_addr_o), .data(wr_data_o), .idle(w_idle)
    );

    always_comb begin
        nxt     = st;
        f_go    = 1'b0;
        f_ld    = 1'b0;
        f_n     = 4'd0;
        w_go    = 1'b0;
        w_mask  = '0;
        rec_end = 1'b0;
        fin_ok  = 1'b0;
        fin_err = 1'b0;
        fault_c = FAULT_NONE;
        case (st)
            ST_IDLE: if (start_i) begin
                f_ld = 1'b1; f_go = 1'b1; f_n = 4'd8; nxt = ST_SIG;
            end
            ST_SIG: if (f_done) begin
                if (f_val == HDR_SIGNATURE) begin
                    f_go = 1'b1; f_n = 4'd4; nxt = ST_INFO;
                end else begin
                    fin_err = 1'b1; fault_c = FAULT_SIG;
                end
            end
            ST_INFO: if (f_done) begin
                f_go = 1'b1; f_n = 4'd8; nxt = ST_SPARE;
            end
            ST_SPARE: if (f_done) begin
                f_go = 1'b1; f_n = 4'd4; nxt = ST_COUNT;
            end
            ST_COUNT: if (f_done) begin
                if (f_val[31:0] == 32'd0) fin_ok = 1'b1;
                else begin f_go = 1'b1; f_n = 4'd4; nxt = ST_RECHDR; end
            end
            ST_RECHDR: if (f_done) begin
                case (rw.opc)
                    OPC_WR0, OPC_WR1, OPC_WRB: begin
                        f_go = 1'b1; f_n = 4'd2; nxt = ST_WDATA;
                    end
                    OPC_BURST: begin
                        f_go = 1'b1; f_n = 4'd4; nxt = ST_BLEN;
                    end
                    OPC_TRN0, OPC_TRN1: nxt = ST_TRAIN;
                    default: begin fin_err = 1'b1; fault_c = FAULT_OPCODE; end
                endcase
            end
            ST_WDATA: if (f_done) begin
                w_go = 1'b1; w_mask = port_mask(cur_opc); nxt = ST_WRITE;
            end
            ST_WRITE: if (w_idle) rec_end = 1'b1;
            ST_BLEN: if (f_done) begin
                if (f_val[31:0] == 32'd0) rec_end = 1'b1;
                else begin f_go = 1'b1; f_n = 4'd2; nxt = ST_BDATA; end
            end
            ST_BDATA: if (f_done) begin
                w_go = 1'b1; w_mask = '1; nxt = ST_BWRITE;
            end
            ST_BWRITE: if (w_idle) begin
                if (burst_left == 32'd1) rec_end = 1'b1;
                else begin f_go = 1'b1; f_n = 4'd2; nxt = ST_BDATA; end
            end
            ST_TRAIN: begin
                if (train_fail_i) begin fin_err = 1'b1; fault_c = FAULT_TRAIN; end
                else if (train_ok_i) rec_end = 1'b1;
            end
            default: nxt = ST_IDLE;
        endcase
        if (rec_end) begin
            if (recs_left == 32'd1) fin_ok = 1'b1;
            else begin f_go = 1'b1; f_n = 4'd4; nxt = ST_RECHDR; end
        end
        if (fin_ok || fin_err) nxt = ST_IDLE;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st         <= ST_IDLE;
            recs_left  <= '0;
            burst_left <= '0;
            cur_opc    <= '0;
            cur_addr   <= '0;
            done_q     <= 1'b0;
            err_q      <= 1'b0;
            code_q     <= FAULT_NONE;
        end else begin
            st     <= nxt;
            done_q <= fin_ok;
            err_q  <= fin_err;
            if (st == ST_IDLE && start_i) code_q <= FAULT_NONE;
            if (fin_err) code_q <= fault_c;
            if (st == ST_COUNT && f_done) recs_left <= f_val[31:0];
            else if (rec_end) recs_left <= recs_left - 32'd1;
            if (st == ST_RECHDR && f_done) begin
                cur_opc  <= rw.opc;
                cur_addr <= {rw.idx, 1'b0};
            end
            if (st == ST_BLEN && f_done) burst_left <= f_val[31:0];
            if (st == ST_BWRITE && w_idle && burst_left != 32'd1) begin
                burst_left <= burst_left - 32'd1;
                cur_addr   <= cur_addr + 2'd2;
            end
        end
    end

    assign train_req_o = (st == ST_TRAIN) ?
                         ((cur_opc == OPC_TRN0) ? 2'b01 : 2'b10) : '0;
    assign done_o      = done_q;
    assign err_o       = err_q;
    assign err_code_o  = code_q;
endmodule

// File: rtl/cfgs_checker.sv
module cfgs_checker #(
    parameter int MEM_AW = 16,
    parameter int NPHY   = 2,
    parameter int PA_W   = 25,
    parameter int DW     = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              mem_rd_o,
    input logic [MEM_AW-1:0] mem_addr_o,
    input logic              mem_rvalid_i,
    input logic [NPHY-1:0]   wr_valid_o,
    input logic [NPHY-1:0]   wr_ready_i,
    input logic [PA_W-1:0]   wr_addr_o,
    input logic [DW-1:0]     wr_data_o,
    input logic [NPHY-1:0]   train_req_o,
    input logic              done_o,
    input logic              err_o,
    input logic [1:0]        err_code_o
);
    logic wrote;

    always_ff @(posedge clk) begin
        if (rst)                 wrote <= 1'b0;
        else if (done_o || err_o) wrote <= 1'b0;
        else if ((wr_valid_o & wr_ready_i) != '0) wrote <= 1'b1;
    end

    AST_RD_HOLD: assert property (@(posedge clk) disable iff (rst)
        mem_rd_o && !mem_rvalid_i |=> mem_rd_o && $stable(mem_addr_o)); // R11

    for (genvar p = 0; p < NPHY; p++) begin : g_hold
        AST_WR_HOLD: assert property (@(posedge clk) disable iff (rst)
            wr_valid_o[p] && !wr_ready_i[p] |=> wr_valid_o[p] && $stable(wr_addr_o) && $stable(wr_data_o)); // R12
    end

    AST_SIG_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
        err_o && err_code_o == 2'd1 |-> !wrote); // R1

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o); // R10

    AST_DONE_NOT_ERR: assert property (@(posedge clk) disable iff (rst)
        done_o |-> !err_o); // R10

    AST_TRAIN_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(train_req_o)); // R7

    AST_TRAIN_AFTER_WRITES: assert property (@(posedge clk) disable iff (rst)
        train_req_o != '0 |-> wr_valid_o == '0); // R5
endmodule

bind cfgs_stream_exec cfgs_checker #(
    .MEM_AW(MEM_AW), .NPHY(NPHY), .PA_W(PA_W), .DW(DW)
) chk_i (.*);

// File: tb/cfgs_stream_exec_tb_top.sv
module cfgs_stream_exec_tb_top;
    localparam logic [63:0] SIG = 64'h4452444445415448;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start_i = 1'b0;
    logic [15:0] base_i = '0;
    logic        mem_rd_o;
    logic [15:0] mem_addr_o;
    logic        mem_rvalid_i = 1'b0;
    logic [7:0]  mem_rdata_i = '0;
    logic [1:0]  wr_valid_o;
    logic [1:0]  wr_ready_i = '0;
    logic [24:0] wr_addr_o;
    logic [15:0] wr_data_o;
    logic [1:0]  train_req_o;
    logic        train_ok_i = 1'b0;
    logic        train_fail_i = 1'b0;
    logic        done_o, err_o;
    logic [1:0]  err_code_o;

    cfgs_stream_exec dut_i (.*);

    always #4 clk = ~clk;

    int tests = 0, fails = 0, cycles = 0;
    logic [7:0]  mem [1024];
    int          wp;
    logic [40:0] exp_w [2][256];
    int          exp_n [2];
    logic [40:0] got_w [2][256];
    int          got_n [2];
    logic        exp_on;
    logic        tr_fail [64];
    int          tr_n, tr_ptr;
    logic [1:0]  hold = '0;
    logic        saw_done, saw_err;
    logic [1:0]  saw_code;

    task automatic chk(input logic ok, input string req, input logic [63:0] act, input logic [63:0] expv);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    task automatic put8(input logic [7:0] b); mem[wp % 1024] = b; wp++; endtask
    task automatic put16(input logic [15:0] v); put8(v[7:0]); put8(v[15:8]); endtask
    task automatic put32(input logic [31:0] v);
        for (int b = 0; b < 4; b++) put8(v[8*b +: 8]);
    endtask

    task automatic push(input int p, input logic [24:0] a, input logic [15:0] d);
        exp_w[p][exp_n[p]] = {a, d};
        exp_n[p]++;
    endtask

    task automatic begin_stream(input int base, input int count);
        wp = base; base_i = 16'(base);
        exp_n[0] = 0; exp_n[1] = 0; tr_n = 0; tr_ptr = 0; exp_on = 1'b1;
        put32(SIG[31:0]); put32(SIG[63:32]);
        put32($urandom); put32(0); put32(32'hFFFF_FFFF);
        put32(32'(count));
    endtask

    task automatic rec_phy(input logic [7:0] op, input logic [23:0] idx, input logic [15:0] d);
        put32({op, idx}); put16(d);
        if (exp_on) begin
            if (op != 8'd1) push(0, {idx, 1'b0}, d);
            if (op != 8'd0) push(1, {idx, 1'b0}, d);
        end
    endtask

    task automatic rec_burst(input logic [23:0] idx, input int n);
        put32({8'd3, idx}); put32(32'(n));
        for (int j = 0; j < n; j++) begin
            logic [15:0] d;
            d = 16'($urandom);
            put16(d);
            if (exp_on) begin
                push(0, {idx, 1'b0} + 25'(2*j), d);
                push(1, {idx, 1'b0} + 25'(2*j), d);
            end
        end
    endtask

    task automatic rec_train(input int phy, input logic ok);
        put32({8'(4 + phy), 24'(tr_n)});
        tr_fail[tr_n] = !ok; tr_n++;
        if (!ok) exp_on = 1'b0;
    endtask

    task automatic run_stream();
        int t;
        got_n[0] = 0; got_n[1] = 0; saw_done = 0; saw_err = 0; t = 0;
        @(negedge clk); start_i = 1'b1;
        @(negedge clk); start_i = 1'b0;
        while (!saw_done && !saw_err && t < 20000) begin
            if (done_o) saw_done = 1'b1;
            if (err_o) begin saw_err = 1'b1; saw_code = err_code_o; end
            if (!saw_done && !saw_err) @(negedge clk);
            t++;
        end
        repeat (4) @(negedge clk);
    endtask

    task automatic compare_writes(input string req);
        for (int p = 0; p < 2; p++) begin
            chk(got_n[p] == exp_n[p], req, 64'(got_n[p]), 64'(exp_n[p]));
            for (int i = 0; i < exp_n[p] && i < got_n[p]; i++)
                chk(got_w[p][i] == exp_w[p][i], req, 64'(got_w[p][i]), 64'(exp_w[p][i]));
        end
    endtask

    // memory responder
    initial forever begin
        @(negedge clk);
        if (mem_rd_o) begin
            repeat ($urandom % 3) @(negedge clk);
            mem_rdata_i = mem[mem_addr_o % 1024];
            mem_rvalid_i = 1'b1;
            @(negedge clk);
            mem_rvalid_i = 1'b0;
        end
    end

    // PHY port models: decide ready, log the handshake taking place at the next edge
    initial forever begin
        @(negedge clk);
        for (int p = 0; p < 2; p++) begin
            wr_ready_i[p] = !hold[p] && ($urandom % 4 != 0);
            if (wr_valid_o[p] && wr_ready_i[p]) begin
                got_w[p][got_n[p] % 256] = {wr_addr_o, wr_data_o};
                got_n[p]++;
            end
        end
    end

    // training result responder
    initial forever begin
        @(negedge clk);
        if (train_req_o != 2'b00) begin
            repeat (1 + $urandom % 3) @(negedge clk);
            if (tr_fail[tr_ptr % 64]) train_fail_i = 1'b1; else train_ok_i = 1'b1;
            tr_ptr++;
            @(negedge clk);
            train_ok_i = 1'b0; train_fail_i = 1'b0;
        end
    end

    initial forever begin
        @(negedge clk);
        cycles++;
        if (cycles >= 150000) begin
            fails++; tests++;
            $display("FAIL watchdog actual=%0d expected<%0d", cycles, 150000);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        int t;
        void'($urandom(32'd2024));
        for (int i = 0; i < 1024; i++) mem[i] = 8'h00;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // reset state
        chk(!done_o && !err_o && err_code_o == 0, "R10 reset", {done_o, err_o, err_code_o}, 0);
        chk(!mem_rd_o && wr_valid_o == 0 && train_req_o == 0, "R11 reset idle", {mem_rd_o, wr_valid_o, train_req_o}, 0);

        // R1 corrupted signature
        begin_stream(0, 2); rec_phy(8'd0, 24'h10, 16'h1111); rec_phy(8'd2, 24'h11, 16'h2222);
        mem[3] = mem[3] ^ 8'h01;
        exp_n[0] = 0; exp_n[1] = 0;
        run_stream();
        chk(saw_err && !saw_done && saw_code == 2'd1, "R1 signature", {saw_err, saw_done, saw_code}, 64'b1_0_01);
        compare_writes("R1 no writes");

        // R2 zero count, also R10 code cleared by new start
        begin_stream(40, 0);
        run_stream();
        chk(saw_done && !saw_err && err_code_o == 0, "R2 R10 empty", {saw_done, saw_err, err_code_o}, 64'b1_0_00);
        compare_writes("R2 empty");

        // R3 R4 R5 single and broadcast, odd base
        begin_stream(101, 3);
        rec_phy(8'd0, 24'h00ABCD, 16'hBEEF); rec_phy(8'd1, 24'h123456, 16'hCAFE); rec_phy(8'd2, 24'h000003, 16'h5A5A);
        run_stream();
        chk(saw_done && !saw_err, "R4 completion", {saw_done, saw_err}, 2'b10);
        compare_writes("R3 R4 R5 writes");

        // R6 burst N=3 and N=0
        begin_stream(7, 3);
        rec_burst(24'h200, 3); rec_burst(24'h300, 0); rec_phy(8'd1, 24'h44, 16'h0F0F);
        run_stream();
        chk(saw_done && !saw_err, "R6 completion", {saw_done, saw_err}, 2'b10);
        compare_writes("R6 burst");

        // R7 training ok
        begin_stream(300, 3);
        rec_train(0, 1'b1); rec_phy(8'd1, 24'h9, 16'h9999); rec_train(1, 1'b1);
        run_stream();
        chk(saw_done && !saw_err, "R7 train ok", {saw_done, saw_err}, 2'b10);
        compare_writes("R7 train ok");

        // R7 training failure stops the walk
        begin_stream(500, 3);
        rec_phy(8'd2, 24'h21, 16'h7777); rec_train(1, 1'b0); rec_phy(8'd0, 24'h22, 16'h8888);
        run_stream();
        chk(saw_err && saw_code == 2'd3, "R7 train fail", {saw_err, saw_code}, 3'b1_11);
        compare_writes("R7 after fail");

        // R8 unknown opcode
        begin_stream(650, 3);
        rec_phy(8'd0, 24'h31, 16'h1234); put32({8'h09, 24'h0}); exp_on = 1'b0; rec_phy(8'd1, 24'h32, 16'h4321);
        run_stream();
        chk(saw_err && saw_code == 2'd2, "R8 bad opcode", {saw_err, saw_code}, 3'b1_10);
        compare_writes("R8 after bad opcode");

        // R5 broadcast waits for both ports
        begin_stream(800, 2);
        rec_phy(8'd2, 24'h55, 16'hAAAA); rec_phy(8'd0, 24'h56, 16'hBBBB);
        hold[1] = 1'b1;
        got_n[0] = 0; got_n[1] = 0; saw_done = 0; saw_err = 0;
        @(negedge clk); start_i = 1'b1;
        @(negedge clk); start_i = 1'b0;
        t = 0;
        while (got_n[0] < 1 && t < 2000) begin @(negedge clk); t++; end
        repeat (10) @(negedge clk);
        chk(!mem_rd_o && wr_valid_o == 2'b10, "R5 stall", {mem_rd_o, wr_valid_o}, 3'b0_10);
        chk(got_n[0] == 1, "R5 no early fetch", 64'(got_n[0]), 1);
        hold[1] = 1'b0;
        t = 0;
        while (!done_o && !err_o && t < 2000) begin @(negedge clk); t++; end
        chk(done_o, "R5 completion", {done_o, err_o}, 2'b10);
        repeat (4) @(negedge clk);
        compare_writes("R5 broadcast");

        // R9 random packed streams at random bases
        for (int s = 0; s < 20; s++) begin
            int n;
            n = 1 + $urandom % 8;
            begin_stream($urandom % 400, n);
            for (int r = 0; r < n; r++) begin
                case ($urandom % 5)
                    0, 1, 2: rec_phy(8'($urandom % 3), 24'($urandom % 4096), 16'($urandom));
                    3:       rec_burst(24'($urandom % 4096), $urandom % 4);
                    default: rec_train($urandom % 2, 1'b1);
                endcase
            end
            run_stream();
            chk(saw_done && !saw_err, "R9 random completion", {saw_done, saw_err}, 2'b10);
            compare_writes("R9 random");
        end

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule